// File: doc/BRIEF.md
# Segmented Dual-Bank Memory Bridge

This unit sits between a CPU-side request port and a 16-bit memory built from two 8-bit banks. The even bank holds the bytes at even physical addresses. The odd bank holds the bytes at odd physical addresses. A request carries a 16-bit segment and a 16-bit offset. The bridge builds a 20-bit physical address from them. It shifts the segment four bit positions to the left and adds the offset. Any carry out of the 20 bits is dropped.

Each request is a read or a write, of one byte or one 16-bit word. The bridge issues one or two single-clock bus cycles for it. In each cycle it selects the banks with an active-low high-byte enable and with address bit 0, and it puts the bytes on the correct data lanes. A word at an odd address is split into two cycles without any help from the CPU side. When the transfer is finished, the bridge raises a one-clock completion pulse, and on reads it presents the assembled data at the same time.

Top module: `seg_mem_bridge`

## Requirements
- R1: The address of the first bus cycle equals (segment × 16 + offset) taken modulo 2^20; for example, segment 0x1000 with offset 0x2000 gives 0x12000.
- R2: The address computation wraps at 2^20. Segment 0xFFFF with offset 0xFFFF gives 0x0FFEF. When the second half of a split word would fall past 0xFFFFF, it goes to 0x00000.
- R3: A byte access at an even address is a single cycle with mem_bhe_n=1 and mem_addr[0]=0. The byte travels on lanes 7..0. A read returns that byte in rsp_rdata[7:0] with the upper byte zero. A write leaves the odd byte of the same pair unchanged.
- R4: A byte access at an odd address is a single cycle with mem_bhe_n=0 and mem_addr[0]=1. The byte travels on lanes 15..8. A read returns it moved to rsp_rdata[7:0] with the upper byte zero. A write leaves the even byte of the pair unchanged.
- R5: A word access at an even address is a single cycle with mem_bhe_n=0 and mem_addr[0]=0. The low byte sits at the given address and the high byte at the next address.
- R6: A word access at an odd address takes exactly two consecutive cycles. The first goes to the given address with mem_bhe_n=0 and carries the low byte on lanes 15..8. The second goes to the next address with mem_bhe_n=1 and carries the high byte on lanes 7..0. The read result is reassembled as {high, low}.
- R7: A bus cycle never uses mem_bhe_n=1 together with mem_addr[0]=1, because that combination selects no bank.
- R8: rsp_done is high for exactly one clock, in the clock that follows the last bus cycle, and rsp_rdata is valid in that clock. After a request is accepted, rsp_done appears two rising edges later for a single-cycle access and three for a split word.
- R9: While busy is high, req_valid is ignored. The request does not add a bus cycle and does not write memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset value |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| busy | output | 1 | Transfer in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| mem_en | output | 1 | Bus cycle active this clock |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 20 | Physical address of the cycle |
| mem_bhe_n | output | 1 | Active-low odd-bank (high byte) enable |
| mem_wdata | output | 16 | Write lanes: 15..8 odd bank, 7..0 even bank |
| mem_rdata | input | 16 | Read lanes, sampled at the end of the cycle |

## Verification
The random stimulus covers all four combinations of access width and address parity, in both directions. Read results can only be correct if the lanes were steered the right way, and the neighbouring byte of each pair shows whether a byte write touched the wrong bank. Directed cases use the 0x1000:0x2000 example to check how segment and offset combine. Wrap-around cases, one in the sum and one in the second half of a split word, show whether the 20-bit carry is dropped. During each transfer the bench issues a second request to a separate address, which separates a bridge that ignores new work while busy from one that accepts it.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;
    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_SPLIT = 2'd2,
        ST_DONE  = 2'd3
    } bridge_st_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    logic [ADDR_W-1:0] base;

    generate
        if (SEG_SHIFT == 0) begin : g_noshift
            assign base = ADDR_W'(seg);
        end else begin : g_shift
            assign base = ADDR_W'({seg, {SEG_SHIFT{1'b0}}});
        end
    endgenerate

    // Sum is truncated to ADDR_W bits: carry out is dropped (wrap)
    assign phys = base + ADDR_W'(off);
endmodule

// File: rtl/seg_lane_steer.sv
module seg_lane_steer
    import seg_mem_pkg::*;
(
    input  logic             addr_lsb,
    input  logic             is_word,
    input  logic             second,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] bus_rd,
    input  logic [BUS_W-1:0] rd_acc,
    output logic             bhe_n,
    output logic [BUS_W-1:0] bus_wd,
    output logic [BUS_W-1:0] rd_next
);
    localparam logic [LANE_W-1:0] ZB = '0;

    logic [LANE_W-1:0] lo_w, hi_w, lo_r, hi_r;

    assign lo_w = wdata[LANE_W-1:0];
    assign hi_w = wdata[BUS_W-1:LANE_W];
    assign lo_r = bus_rd[LANE_W-1:0];
    assign hi_r = bus_rd[BUS_W-1:LANE_W];

    always_comb begin
        if (second) begin
            // Upper half of a split word: even bank only
            bhe_n   = 1'b1;
            bus_wd  = {ZB, hi_w};
            rd_next = {lo_r, rd_acc[LANE_W-1:0]};
        end else if (is_word && !addr_lsb) begin
            bhe_n   = 1'b0;
            bus_wd  = wdata;
            rd_next = bus_rd;
        end else if (addr_lsb) begin
            // Odd byte, or low half of a split word: odd bank only
            bhe_n   = 1'b0;
            bus_wd  = {lo_w, ZB};
            rd_next = {ZB, hi_r};
        end else begin
            bhe_n   = 1'b1;
            bus_wd  = {ZB, lo_w};
            rd_next = {ZB, lo_r};
        end
    end
endmodule

// File: rtl/seg_mem_bridge.sv
module seg_mem_bridge
    import seg_mem_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              busy,
    output logic              rsp_done,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_bhe_n,
    output logic [BUS_W-1:0]  mem_wdata,
    input  logic [BUS_W-1:0]  mem_rdata
);
    typedef struct packed {
        bridge_st_e        st;
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              wr;
        logic [BUS_W-1:0]  wdata;
        logic [BUS_W-1:0]  rdata;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [ADDR_W-1:0] phys_w;
    logic [ADDR_W-1:0] cyc_addr;
    logic              in_split;
    logic [BUS_W-1:0]  rd_next;

    seg_addr_gen #(
        .SEG_W     (SEG_W),
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT),
        .ADDR_W    (ADDR_W)
    ) addr_i (
        .seg  (req_seg),
        .off  (req_off),
        .phys (phys_w)
    );

    assign in_split = (ctx_q.st == ST_SPLIT);
    assign cyc_addr = in_split ? ctx_q.addr + ADDR_W'(1) : ctx_q.addr;

    seg_lane_steer steer_i (
        .addr_lsb (cyc_addr[0]),
        .is_word  (ctx_q.word),
        .second   (in_split),
        .wdata    (ctx_q.wdata),
        .bus_rd   (mem_rdata),
        .rd_acc   (ctx_q.rdata),
        .bhe_n    (mem_bhe_n),
        .bus_wd   (mem_wdata),
        .rd_next  (rd_next)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.st    = ST_FIRST;
                    ctx_d.addr  = phys_w;
                    ctx_d.word  = req_word;
                    ctx_d.wr    = req_write;
                    ctx_d.wdata = req_wdata;
                end
            end
            ST_FIRST: begin
                if (!ctx_q.wr) ctx_d.rdata = rd_next;
                ctx_d.st = (ctx_q.word && ctx_q.addr[0]) ? ST_SPLIT : ST_DONE;
            end
            ST_SPLIT: begin
                if (!ctx_q.wr) ctx_d.rdata = rd_next;
                ctx_d.st = ST_DONE;
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, addr: '0, word: 1'b0, wr: 1'b0,
                       wdata: '0, rdata: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_en    = (ctx_q.st == ST_FIRST) || in_split;
    assign mem_we    = mem_en && ctx_q.wr;
    assign mem_addr  = cyc_addr;
    assign busy      = (ctx_q.st != ST_IDLE);
    assign rsp_done  = (ctx_q.st == ST_DONE);
    assign rsp_rdata = ctx_q.rdata;
endmodule

// File: rtl/seg_mem_bridge_chk.sv
module seg_mem_bridge_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_bhe_n,
    input logic              rsp_done,
    input logic              busy
);
    // R7: a bus cycle never selects neither bank
    assert_no_dead_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !(mem_bhe_n && mem_addr[0]));

    // R8: completion is a single-clock pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8: completion directly follows a bus cycle
    assert_done_after_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(mem_en));

    // R6: back-to-back cycles are the even upper half at the next address
    assert_split_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |->
            (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)) && mem_bhe_n && !mem_addr[0]);

    // R9: bus activity only inside an accepted transfer
    assert_cycle_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R8: no bus cycle in the clock after completion
    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !mem_en);
endmodule

bind seg_mem_bridge seg_mem_bridge_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .mem_bhe_n (mem_bhe_n),
    .rsp_done  (rsp_done),
    .busy      (busy)
);

// File: tb/seg_mem_bridge_tb_top.sv
module seg_mem_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_done, mem_en, mem_we, mem_bhe_n;
    logic [15:0] rsp_rdata, mem_wdata;
    logic [19:0] mem_addr;
    logic [15:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_cnt = 0;

    seg_mem_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_word(req_word), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_bhe_n(mem_bhe_n), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- memory model (two byte banks) ----------------
    logic [7:0] bmem [logic [19:0]];

    function automatic logic [7:0] byte_at(input logic [19:0] a);
        if (bmem.exists(a)) return bmem[a];
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
    endfunction

    int          bus_total = 0;
    logic [19:0] log_addr [8];
    logic        log_bhe  [8];

    always @(posedge clk) begin
        if (rst_n && mem_en) begin
            log_addr[bus_total % 8] <= mem_addr;
            log_bhe[bus_total % 8]  <= mem_bhe_n;
            bus_total <= bus_total + 1;
            if (mem_we) begin
                if (!mem_addr[0]) bmem[{mem_addr[19:1], 1'b0}] = mem_wdata[7:0];
                if (!mem_bhe_n)   bmem[{mem_addr[19:1], 1'b1}] = mem_wdata[15:8];
            end
        end
    end

    always @(negedge clk)
        mem_rdata <= {byte_at({mem_addr[19:1], 1'b1}), byte_at({mem_addr[19:1], 1'b0})};

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] phys_of(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic string kind_tag(input bit word, input logic [19:0] p);
        if (word) return p[0] ? "R6" : "R5";
        return p[0] ? "R4" : "R3";
    endfunction

    task automatic run(input logic [15:0] s, input logic [15:0] o, input bit word,
                       input bit wr, input logic [15:0] wd, input bit spur,
                       input string xtag);
        logic [19:0] p, p1, nb, sp;
        logic [7:0]  b0, b1, bnb, bsp;
        logic [15:0] exp_rd, got_rd;
        int          start, lat, ncyc, exp_lat;
        bit          split;
        string       kt;
        p = phys_of(s, o);
        p1 = p + 20'd1;
        nb = p ^ 20'd1;
        sp = p ^ 20'h80000;
        split = word && p[0];
        kt = kind_tag(word, p);
        b0 = byte_at(p); b1 = byte_at(p1); bnb = byte_at(nb); bsp = byte_at(sp);
        exp_rd = word ? {b1, b0} : {8'h00, b0};
        exp_lat = split ? 3 : 2;
        start = bus_total;

        req_seg = s; req_off = o; req_word = word; req_write = wr;
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        lat = 1;
        if (spur) begin
            // R9: a competing write request while the transfer runs
            req_seg = s ^ 16'h8000; req_word = 1'b1; req_write = 1'b1;
            req_wdata = ~wd; req_valid = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        while (!rsp_done && lat < 20) begin
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
        end
        req_valid = 1'b0;
        got_rd = rsp_rdata;
        chk(lat == exp_lat, "R8 done latency", lat, exp_lat);
        @(negedge clk);
        chk(!rsp_done, "R8 done one clock only", rsp_done, 0);
        @(negedge clk);
        @(negedge clk);
        ncyc = bus_total - start;

        chk(ncyc == (split ? 2 : 1), {kt, " R9 bus cycle count"}, ncyc, split ? 2 : 1);
        chk(log_addr[start % 8] == p, {"R1 ", xtag, " first address"},
            log_addr[start % 8], p);
        chk(log_bhe[start % 8] == !(word || p[0]), {kt, " bank enable"},
            log_bhe[start % 8], !(word || p[0]));
        chk(!(log_bhe[start % 8] && log_addr[start % 8][0]), "R7 dead cycle",
            {log_bhe[start % 8], log_addr[start % 8][0]}, 0);
        if (split) begin
            chk(log_addr[(start + 1) % 8] == p1, {"R6 ", xtag, " second address"},
                log_addr[(start + 1) % 8], p1);
            chk(log_bhe[(start + 1) % 8] == 1'b1, "R6 second cycle even only",
                log_bhe[(start + 1) % 8], 1);
        end
        if (wr) begin
            chk(byte_at(p) == wd[7:0], {kt, " written low byte"}, byte_at(p), wd[7:0]);
            if (word)
                chk(byte_at(p1) == wd[15:8], {kt, " written high byte"},
                    byte_at(p1), wd[15:8]);
            else
                chk(byte_at(nb) == bnb, {kt, " neighbour byte kept"}, byte_at(nb), bnb);
        end else begin
            chk(got_rd == exp_rd, {kt, " read data"}, got_rd, exp_rd);
        end
        if (spur && sp != p && sp != p1)
            chk(byte_at(sp) == bsp, "R9 ignored request wrote nothing", byte_at(sp), bsp);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt >= WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc_cnt, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd8086));
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_done && !mem_en, "R8 reset idle",
            {busy, rsp_done, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(16'h1000, 16'h2000, 1'b1, 1'b0, 16'h0000, 1'b0, "example");
        run(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'h00C3, 1'b0, "R2 wrap sum");
        run(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 16'h0000, 1'b0, "R2 wrap sum");
        run(16'hF000, 16'hFFFF, 1'b1, 1'b1, 16'hBEEF, 1'b1, "R2 wrap split");
        run(16'hF000, 16'hFFFF, 1'b1, 1'b0, 16'h0000, 1'b0, "R2 wrap split");
        run(16'h0123, 16'h0004, 1'b0, 1'b1, 16'h11A5, 1'b1, "even byte");
        run(16'h0123, 16'h0005, 1'b0, 1'b1, 16'h225A, 1'b1, "odd byte");
        run(16'h0123, 16'h0004, 1'b1, 1'b0, 16'h0000, 1'b0, "even word");
        run(16'h0123, 16'h0005, 1'b1, 1'b1, 16'h1234, 1'b1, "odd word");
        run(16'h0123, 16'h0005, 1'b1, 1'b0, 16'h0000, 1'b0, "odd word");

        for (int i = 0; i < 150; i++) begin
            logic [15:0] s, o, w;
            s = 16'($urandom);
            o = 16'($urandom);
            w = 16'($urandom);
            run(s, o, 1'($urandom), 1'($urandom), w, 1'($urandom), "random");
            if (i % 3 == 0) run(s, o, 1'($urandom), 1'b0, 16'h0, 1'b0, "readback");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule